// File: doc/BRIEF.md
# Turbo Code Block Segmentation Calculator

This block takes the length in bits of a concatenated transport block and works out how that payload is split for a turbo coder. It returns how many code blocks are needed, the common size of each block, how many filler bits pad the payload up to a whole number of equal blocks, the coded length of one block, and the coded length of all blocks together. Downstream logic uses these numbers to drive filler insertion, the encoder or decoder, and rate matching.

A request is a bit count offered with a valid/ready handshake while the block is idle. The block runs two ceiling divisions one after the other on a single shared restoring divider. The first finds the block count against a 5114-bit ceiling. The second finds the per-block size. A one-cycle done pulse then presents the results, which hold until the next done pulse. Payloads that are empty, or that would need more than three blocks, end with an error indication and zeroed results.

Top module: `turbo_seg_calc`

## Requirements
- R1: An asynchronous active-low reset, at any time, forces in_ready high, done and err low, and every result output to zero.
- R2: A request is taken on a clock edge where in_valid and in_ready are both high. in_ready stays low from the cycle after a nonzero request is taken until the cycle in which done is high, and it is high in that done cycle.
- R3: For 1 ≤ X ≤ 15342, num_blk is the smallest C with C·5114 ≥ X (1, 2 or 3, unsigned binary).
- R4: For X ≥ 40 without error, blk_size is the smallest K with K·C ≥ X, and it never exceeds 5114.
- R5: For 1 ≤ X ≤ 39, num_blk is 1 and blk_size is 40.
- R6: Without error, fill_bits equals num_blk·blk_size − X and lies in 0 to 39.
- R7: Without error, enc_per_blk equals 3·blk_size + 12 and enc_total equals enc_per_blk·num_blk.
- R8: For X = 0 or X > 15342, done comes with err high and num_blk, blk_size, fill_bits, enc_per_blk and enc_total all zero.
- R9: done is high for exactly one cycle per request, and every result output keeps its value between done pulses.
- R10: A request presented in the cycle where done is high is taken at that cycle's closing edge and starts a new computation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low, released synchronously |
| in_valid | input | 1 | Request carries a bit count |
| in_bits | input | 15 | Transport block length X in bits |
| in_ready | output | 1 | Block is idle and can take a request |
| done | output | 1 | One-cycle pulse when results are presented |
| err | output | 1 | Request was empty or needs more than three blocks |
| num_blk | output | 2 | Number of code blocks C |
| blk_size | output | 13 | Code block size K in bits |
| fill_bits | output | 6 | Filler bit count F |
| enc_per_blk | output | 15 | Coded length of one block, 3K+12 |
| enc_total | output | 17 | Coded length of all blocks |

## Verification
The done pulse that ends one computation and the acceptance of the next request can fall in the same cycle, because in_ready returns high exactly when done is shown. The bench provokes this by issuing most requests back to back, with the next bit count already on in_valid at the done cycle. It then judges that the request was taken (done low and in_ready low one cycle later) and that the previous results stayed unchanged while the new computation ran. Random payload lengths around the 5114-bit multiples and the 40-bit floor, plus directed limits, are compared against segmentation values computed in bench functions.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int XW   = 15;   // payload length width
  localparam int CW   = 2;    // block count width
  localparam int KW   = 13;   // block size width
  localparam int FW   = 6;    // filler width
  localparam int YW   = 15;   // coded length per block width
  localparam int TW   = 17;   // total coded length width
  localparam int DVW  = XW + 1;  // divider dividend width (holds X + KMAX - 1)
  localparam int KMAX = 5114;
  localparam int KMIN = 40;
  localparam int CMAX = 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_SIZE  = 2'd2
  } seg_state_t;
endpackage

// File: rtl/seg_div.sv
module seg_div #(
  parameter int DW = 16,
  parameter int VW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] dividend,
  input  logic [VW-1:0] divisor,
  output logic          busy,
  output logic          fin,
  output logic [DW-1:0] quot
);
  localparam int CNTW = $clog2(DW + 1);

  logic            busy_q, busy_d;
  logic            fin_q, fin_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic [VW-1:0]   rem_q, rem_d;
  logic [VW-1:0]   dvs_q, dvs_d;
  logic [DW-1:0]   acc_q, acc_d;
  logic [VW:0]     trial;
  logic [VW:0]     diff;
  logic            qbit;

  always_comb begin
    busy_d = busy_q;
    fin_d  = 1'b0;
    cnt_d  = cnt_q;
    rem_d  = rem_q;
    dvs_d  = dvs_q;
    acc_d  = acc_q;
    trial  = {rem_q, acc_q[DW-1]};
    diff   = trial - {1'b0, dvs_q};
    qbit   = (trial >= {1'b0, dvs_q});
    if (start && !busy_q) begin
      busy_d = 1'b1;
      cnt_d  = CNTW'(DW);
      rem_d  = '0;
      dvs_d  = divisor;
      acc_d  = dividend;
    end else if (busy_q) begin
      rem_d = qbit ? diff[VW-1:0] : trial[VW-1:0];
      acc_d = {acc_q[DW-2:0], qbit};
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CNTW'(1)) begin
        busy_d = 1'b0;
        fin_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      dvs_q  <= '0;
      acc_q  <= '0;
    end else begin
      busy_q <= busy_d;
      fin_q  <= fin_d;
      cnt_q  <= cnt_d;
      rem_q  <= rem_d;
      dvs_q  <= dvs_d;
      acc_q  <= acc_d;
    end
  end

  assign busy = busy_q;
  assign fin  = fin_q;
  assign quot = acc_q;

  AST_DIV_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy_q) |-> (divisor != '0)); // R3
  AST_DIV_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q); // R2
endmodule

// File: rtl/seg_calc.sv
module seg_calc
  import seg_pkg::*;
(
  input  logic [XW-1:0]  x,
  input  logic [CW-1:0]  c,
  input  logic [DVW-1:0] q,
  output logic [KW-1:0]  k,
  output logic [FW-1:0]  f,
  output logic [YW-1:0]  y,
  output logic [TW-1:0]  tot
);
  logic [TW-1:0] ck;

  always_comb begin
    k   = (x < XW'(KMIN)) ? KW'(KMIN) : q[KW-1:0];
    ck  = TW'(c) * TW'(k);
    f   = FW'(ck - TW'(x));
    y   = YW'(k) * YW'(3) + YW'(12);
    tot = TW'(y) * TW'(c);
  end
endmodule

// File: rtl/turbo_seg_calc.sv
module turbo_seg_calc
  import seg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [14:0]   in_bits,
  output logic          in_ready,
  output logic          done,
  output logic          err,
  output logic [1:0]    num_blk,
  output logic [12:0]   blk_size,
  output logic [5:0]    fill_bits,
  output logic [14:0]   enc_per_blk,
  output logic [16:0]   enc_total
);
  seg_state_t     state_q, state_d;
  logic [XW-1:0]  x_q, x_d;
  logic [CW-1:0]  c_q, c_d;
  logic           done_q, done_d;
  logic           err_q, err_d;
  logic [CW-1:0]  nb_q, nb_d;
  logic [KW-1:0]  k_q, k_d;
  logic [FW-1:0]  f_q, f_d;
  logic [YW-1:0]  y_q, y_d;
  logic [TW-1:0]  t_q, t_d;

  logic           div_start, div_busy, div_fin;
  logic [DVW-1:0] div_dvd, div_quot;
  logic [KW-1:0]  div_dvs;
  logic [KW-1:0]  calc_k;
  logic [FW-1:0]  calc_f;
  logic [YW-1:0]  calc_y;
  logic [TW-1:0]  calc_t;

  seg_div #(.DW(DVW), .VW(KW)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (div_start),
    .dividend (div_dvd),
    .divisor  (div_dvs),
    .busy     (div_busy),
    .fin      (div_fin),
    .quot     (div_quot)
  );

  seg_calc u_calc (
    .x   (x_q),
    .c   (c_q),
    .q   (div_quot),
    .k   (calc_k),
    .f   (calc_f),
    .y   (calc_y),
    .tot (calc_t)
  );

  always_comb begin
    state_d   = state_q;
    x_d       = x_q;
    c_d       = c_q;
    done_d    = 1'b0;
    err_d     = err_q;
    nb_d      = nb_q;
    k_d       = k_q;
    f_d       = f_q;
    y_d       = y_q;
    t_d       = t_q;
    div_start = 1'b0;
    div_dvd   = '0;
    div_dvs   = '0;
    case (state_q)
      ST_IDLE: begin
        if (in_valid) begin
          x_d = in_bits;
          if (in_bits == '0) begin
            done_d = 1'b1;
            err_d  = 1'b1;
            nb_d = '0; k_d = '0; f_d = '0; y_d = '0; t_d = '0;
          end else begin
            div_start = 1'b1;
            div_dvd   = DVW'(in_bits) + DVW'(KMAX - 1);
            div_dvs   = KW'(KMAX);
            state_d   = ST_COUNT;
          end
        end
      end
      ST_COUNT: begin
        if (div_fin) begin
          if (div_quot > DVW'(CMAX)) begin
            done_d  = 1'b1;
            err_d   = 1'b1;
            nb_d = '0; k_d = '0; f_d = '0; y_d = '0; t_d = '0;
            state_d = ST_IDLE;
          end else begin
            c_d       = div_quot[CW-1:0];
            div_start = 1'b1;
            div_dvd   = DVW'(x_q) + DVW'(div_quot[CW-1:0]) - DVW'(1);
            div_dvs   = KW'(div_quot[CW-1:0]);
            state_d   = ST_SIZE;
          end
        end
      end
      ST_SIZE: begin
        if (div_fin) begin
          done_d  = 1'b1;
          err_d   = 1'b0;
          nb_d    = c_q;
          k_d     = calc_k;
          f_d     = calc_f;
          y_d     = calc_y;
          t_d     = calc_t;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      x_q     <= '0;
      c_q     <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      nb_q    <= '0;
      k_q     <= '0;
      f_q     <= '0;
      y_q     <= '0;
      t_q     <= '0;
    end else begin
      state_q <= state_d;
      x_q     <= x_d;
      c_q     <= c_d;
      done_q  <= done_d;
      err_q   <= err_d;
      nb_q    <= nb_d;
      k_q     <= k_d;
      f_q     <= f_d;
      y_q     <= y_d;
      t_q     <= t_d;
    end
  end

  assign in_ready    = (state_q == ST_IDLE);
  assign done        = done_q;
  assign err         = err_q;
  assign num_blk     = nb_q;
  assign blk_size    = k_q;
  assign fill_bits   = f_q;
  assign enc_per_blk = y_q;
  assign enc_total   = t_q;

  AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_bits != '0) |=> !in_ready); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(in_valid && in_ready && in_bits == '0)) |=> !done); // R9
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (num_blk == '0 && blk_size == '0 && fill_bits == '0
                       && enc_per_blk == '0 && enc_total == '0)); // R8
  AST_K_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (blk_size >= 13'(KMIN) && blk_size <= 13'(KMAX))); // R4
  AST_FILL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (fill_bits <= 6'd39 && num_blk != 2'd0)); // R6
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !done_d |=> ($stable(blk_size) && $stable(enc_total) && $stable(num_blk))); // R9
endmodule

// File: tb/turbo_seg_calc_test.sv
module turbo_seg_calc_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [14:0] in_bits = '0;
  logic        in_ready, done, err;
  logic [1:0]  num_blk;
  logic [12:0] blk_size;
  logic [5:0]  fill_bits;
  logic [14:0] enc_per_blk;
  logic [16:0] enc_total;

  int n_checks = 0;
  int n_fail   = 0;
  int prev_c = 0, prev_k = 0, prev_t = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  turbo_seg_calc uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bits(in_bits),
    .in_ready(in_ready), .done(done), .err(err), .num_blk(num_blk),
    .blk_size(blk_size), .fill_bits(fill_bits), .enc_per_blk(enc_per_blk),
    .enc_total(enc_total)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model(input int x, output int e_err, output int e_c,
                       output int e_k, output int e_f, output int e_y, output int e_t);
    int c;
    c = 1;
    while (c * 5114 < x) c++;
    if (x == 0 || c > 3) begin
      e_err = 1; e_c = 0; e_k = 0; e_f = 0; e_y = 0; e_t = 0;
    end else begin
      e_err = 0;
      e_c   = c;
      e_k   = (x < 40) ? 40 : (x + c - 1) / c;
      e_f   = c * e_k - x;
      e_y   = 3 * e_k + 12;
      e_t   = e_y * c;
    end
  endtask

  // Called at a falling edge with the block idle (possibly in a done cycle).
  task automatic req(input int x);
    int e_err, e_c, e_k, e_f, e_y, e_t, wait_n;
    bit was_done;
    was_done = done;
    chk("R2 ready before request", int'(in_ready), 1);
    in_valid = 1'b1;
    in_bits  = 15'(x);
    @(posedge clk);
    #1 in_valid = 1'b0;
    @(negedge clk);
    if (x != 0) begin
      chk("R2 ready low after accept", int'(in_ready), 0);
      if (was_done) chk("R10 request taken in done cycle", int'(done), 0);
      chk("R9 blk_size held", int'(blk_size), prev_k);
      chk("R9 enc_total held", int'(enc_total), prev_t);
    end
    wait_n = 0;
    while (!done && wait_n < 500) begin
      @(negedge clk);
      wait_n++;
    end
    model(x, e_err, e_c, e_k, e_f, e_y, e_t);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL R9 no done for X=%0d actual=0 expected=1", x);
    end else begin
      chk("R2 ready in done cycle", int'(in_ready), 1);
      chk("R8 err", int'(err), e_err);
      chk(x < 40 ? "R5 num_blk" : "R3 num_blk", int'(num_blk), e_c);
      chk(x < 40 ? "R5 blk_size" : "R4 blk_size", int'(blk_size), e_k);
      chk("R6 fill_bits", int'(fill_bits), e_f);
      chk("R7 enc_per_blk", int'(enc_per_blk), e_y);
      chk("R7 enc_total", int'(enc_total), e_t);
      prev_c = e_c; prev_k = e_k; prev_t = e_t;
    end
  endtask

  task automatic gap(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == 0) chk("R9 done one cycle", int'(done), 0);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int dir [12] = '{1, 39, 40, 41, 5114, 5115, 10228, 10229, 15342, 15343, 0, 32767};
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk("R1 reset ready", int'(in_ready), 1);
    chk("R1 reset done", int'(done), 0);
    chk("R1 reset err", int'(err), 0);
    chk("R1 reset blk_size", int'(blk_size), 0);
    chk("R1 reset enc_total", int'(enc_total), 0);
    rst_n = 1'b1;
    @(negedge clk);

    foreach (dir[i]) begin
      req(dir[i]);
      if (i % 3 == 2) gap(2);
    end

    for (int i = 0; i < 80; i++) begin
      int r, x;
      r = int'($urandom % 5);
      case (r)
        0: x = 1 + int'($urandom % 60);
        1: x = 1 + int'($urandom % 15342);
        2: x = 15343 + int'($urandom % 17425);
        3: x = 5114 * (1 + int'($urandom % 3)) - 3 + int'($urandom % 7);
        default: x = 1 + int'($urandom % 32767);
      endcase
      req(x);
      if ($urandom % 3 == 0) gap(1 + int'($urandom % 3));
    end

    // Reset during a computation
    in_valid = 1'b1;
    in_bits  = 15'd9000;
    @(posedge clk);
    #1 in_valid = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset ready", int'(in_ready), 1);
    chk("R1 async reset done", int'(done), 0);
    chk("R1 async reset num_blk", int'(num_blk), 0);
    chk("R1 async reset blk_size", int'(blk_size), 0);
    chk("R1 async reset enc_total", int'(enc_total), 0);
    prev_c = 0; prev_k = 0; prev_t = 0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    req(20);
    req(12000);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule